// File: doc/BRIEF.md
# T1 Receive Frame Timing Generator

This block follows the position of the receive bit stream inside a T1 frame and multiframe and turns that position into timing strobes for downstream logic. Every frame is 193 bit times: one framing bit, then channels 1 to 24 of eight bits each, sent most significant bit first. On every bit clock the block advances a channel/bit counter and, at each frame end, a frame counter whose wrap length follows the selected multiframe format.

From that position it drives four outputs. The first is a main sync pulse that marks either frames or multiframes and can be widened on signaling frames. The second is a frame-only pulse. The third is a multiframe-only pulse. The fourth is a channel-block output that selects timeslots, for example to gate a serial controller in fractional service. A one-cycle resync input realigns the counters to an external frame-alignment decision. The block does no pattern search. It only counts and decodes.

Top module: `t1_rx_timing`

## Requirements
- R1: After reset, and in the cycle after a cycle with `resync` high, the position is the framing bit of frame 1: `fsync_out` and `msync_out` are 1 and `chblk_out` is 0. The following cycle is channel 1, bit 1.
- R2: `fsync_out` is high for exactly one cycle at every framing bit, and consecutive pulses are 193 cycles apart when no resync intervenes.
- R3: A multiframe is 12 frames when `esf_mode`=0 and 24 frames when `esf_mode`=1. `msync_out` is high only during the framing bit of frame 1. At the end of any frame whose number is at or beyond the current multiframe length, the count returns to frame 1.
- R4: With `sync_mf_sel`=1, `sync_out` equals `msync_out` on every cycle.
- R5: With `sync_mf_sel`=0 and `sync_dbl_en`=0, `sync_out` is high only during framing bits, one cycle per frame.
- R6: With `sync_mf_sel`=0 and `sync_dbl_en`=1, the pulse in signaling frames also covers the next cycle (channel 1, bit 1). Signaling frames are frame numbers that are multiples of 6: 6 and 12 in the 12-frame format, and 6, 12, 18 and 24 in the 24-frame format.
- R7: Channel n occupies cycles 1+8(n-1) through 8n after the framing bit. `chblk_out` equals enable bit n-1 for all eight of those cycles.
- R8: `chblk_out` is 0 during every framing bit, whatever the enables are.
- R9: A write with `blk_wr_en`=1 loads `blk_wr_data` into enable byte `blk_wr_addr`: address 0 holds channels 1-8, address 1 holds channels 9-16 and address 2 holds channels 17-24, with the LSB mapping to the lowest channel. The new value is in effect from the next cycle. A write to address 3 changes nothing, and reset clears all enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync | input | 1 | One-cycle realign to frame 1 framing bit |
| esf_mode | input | 1 | 0: 12-frame multiframe, 1: 24-frame multiframe |
| sync_mf_sel | input | 1 | 0: sync_out marks frames, 1: marks multiframes |
| sync_dbl_en | input | 1 | Widen frame sync to two cycles on signaling frames |
| blk_wr_en | input | 1 | Channel-enable byte write strobe |
| blk_wr_addr | input | 2 | Channel-enable byte select |
| blk_wr_data | input | 8 | Channel-enable byte value |
| sync_out | output | 1 | Configurable frame or multiframe sync |
| fsync_out | output | 1 | Frame sync, one cycle per frame |
| msync_out | output | 1 | Multiframe sync, one cycle per multiframe |
| chblk_out | output | 1 | Per-channel block output |

## Verification
Some properties are checked on every cycle. The frame pulse is one cycle wide and 193 cycles apart, and a multiframe pulse always sits on a frame pulse. The block output is low at framing bits and holds steady inside a channel unless a write has just landed. Resync lands on frame 1, and the sync output follows the selected mode. Other behaviour is shown only by the bench's reference model and scenarios. That covers which frames are signaling frames in each format, the exact multiframe length after a format change midstream, the channel-to-bit mapping of the enables, and the fact that an address-3 write has no effect.

// File: rtl/t1_rx_timing_pkg.sv
package t1_rx_timing_pkg;

  // Signaling frames: 1-based frame number is a multiple of the period.
  function automatic logic is_sig_frame(input logic [7:0] frame_idx,
                                        input int unsigned period);
    return ((int'(frame_idx) + 1) % int'(period)) == 0;
  endfunction

  // Index of the last frame of the multiframe for the chosen format.
  function automatic logic [7:0] mf_last_idx(input logic esf,
                                             input int unsigned sf_n,
                                             input int unsigned esf_n);
    return esf ? 8'(esf_n - 1) : 8'(sf_n - 1);
  endfunction

endpackage

// File: rtl/t1_bit_pos.sv
module t1_bit_pos #(
  parameter int CHANNELS    = 24,
  parameter int BITS_PER_CH = 8,
  localparam int CH_W  = $clog2(CHANNELS),
  localparam int BIT_W = $clog2(BITS_PER_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resync,
  output logic             fbit,
  output logic [CH_W-1:0]  ch_idx,
  output logic [BIT_W-1:0] bit_idx,
  output logic             frame_last
);

  logic ch_last_bit;
  assign ch_last_bit = (bit_idx == BIT_W'(BITS_PER_CH - 1));
  assign frame_last  = !fbit && ch_last_bit && (ch_idx == CH_W'(CHANNELS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fbit    <= 1'b1;
      ch_idx  <= '0;
      bit_idx <= '0;
    end else if (resync) begin
      fbit    <= 1'b1;
      ch_idx  <= '0;
      bit_idx <= '0;
    end else if (fbit) begin
      fbit    <= 1'b0;
      ch_idx  <= '0;
      bit_idx <= '0;
    end else if (ch_last_bit) begin
      bit_idx <= '0;
      if (frame_last) fbit <= 1'b1;
      else            ch_idx <= ch_idx + 1'b1;
    end else begin
      bit_idx <= bit_idx + 1'b1;
    end
  end

endmodule

// File: rtl/t1_frame_ctr.sv
module t1_frame_ctr
  import t1_rx_timing_pkg::*;
#(
  parameter int SF_FRAMES  = 12,
  parameter int ESF_FRAMES = 24,
  parameter int SIG_PERIOD = 6,
  localparam int FR_W = $clog2(ESF_FRAMES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            resync,
  input  logic            advance,
  input  logic            esf_mode,
  output logic [FR_W-1:0] frame_idx,
  output logic            mf_first,
  output logic            sig_frame
);

  logic wrap;
  assign wrap      = 8'(frame_idx) >= mf_last_idx(esf_mode, SF_FRAMES, ESF_FRAMES);
  assign mf_first  = (frame_idx == '0);
  assign sig_frame = is_sig_frame(8'(frame_idx), SIG_PERIOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frame_idx <= '0;
    else if (resync)  frame_idx <= '0;
    else if (advance) frame_idx <= wrap ? '0 : frame_idx + 1'b1;
  end

endmodule

// File: rtl/t1_chan_mask.sv
module t1_chan_mask #(
  parameter int CHANNELS = 24,
  parameter int ADDR_W   = 2,
  localparam int NBYTES  = (CHANNELS + 7) / 8,
  localparam int CH_W    = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [CH_W-1:0]   sel_ch,
  output logic              sel_en
);

  logic [NBYTES*8-1:0] mask;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(b))      q <= wr_data;
    end
    assign mask[b*8 +: 8] = q;
  end

  assign sel_en = mask[sel_ch];

endmodule

// File: rtl/t1_rx_timing.sv
module t1_rx_timing #(
  parameter int CHANNELS    = 24,
  parameter int BITS_PER_CH = 8,
  parameter int SF_FRAMES   = 12,
  parameter int ESF_FRAMES  = 24,
  parameter int SIG_PERIOD  = 6,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resync,
  input  logic              esf_mode,
  input  logic              sync_mf_sel,
  input  logic              sync_dbl_en,
  input  logic              blk_wr_en,
  input  logic [ADDR_W-1:0] blk_wr_addr,
  input  logic [7:0]        blk_wr_data,
  output logic              sync_out,
  output logic              fsync_out,
  output logic              msync_out,
  output logic              chblk_out
);

  localparam int FRAME_BITS = 1 + CHANNELS * BITS_PER_CH;
  localparam int CH_W  = $clog2(CHANNELS);
  localparam int BIT_W = $clog2(BITS_PER_CH);
  localparam int FR_W  = $clog2(ESF_FRAMES);

  logic             fbit;
  logic [CH_W-1:0]  ch_idx;
  logic [BIT_W-1:0] bit_idx;
  logic             frame_last;
  logic [FR_W-1:0]  frame_idx;
  logic             mf_first;
  logic             sig_frame;
  logic             ch_en;

  // Named internal events, used by the outputs and by the checker.
  logic frame_start, mf_start, sig_second;

  t1_bit_pos #(.CHANNELS(CHANNELS), .BITS_PER_CH(BITS_PER_CH)) u_pos (
    .clk(clk), .rst_n(rst_n), .resync(resync),
    .fbit(fbit), .ch_idx(ch_idx), .bit_idx(bit_idx), .frame_last(frame_last)
  );

  t1_frame_ctr #(.SF_FRAMES(SF_FRAMES), .ESF_FRAMES(ESF_FRAMES),
                 .SIG_PERIOD(SIG_PERIOD)) u_frm (
    .clk(clk), .rst_n(rst_n), .resync(resync), .advance(frame_last),
    .esf_mode(esf_mode), .frame_idx(frame_idx), .mf_first(mf_first),
    .sig_frame(sig_frame)
  );

  t1_chan_mask #(.CHANNELS(CHANNELS), .ADDR_W(ADDR_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(blk_wr_en), .wr_addr(blk_wr_addr),
    .wr_data(blk_wr_data), .sel_ch(ch_idx), .sel_en(ch_en)
  );

  assign frame_start = fbit;
  assign mf_start    = fbit && mf_first;
  assign sig_second  = !fbit && (ch_idx == '0) && (bit_idx == '0) && sig_frame;

  assign fsync_out = frame_start;
  assign msync_out = mf_start;
  assign sync_out  = sync_mf_sel ? mf_start
                                 : (frame_start || (sync_dbl_en && sig_second));
  assign chblk_out = !fbit && ch_en;

endmodule

// File: rtl/t1_rx_timing_chk.sv
module t1_rx_timing_chk #(
  parameter int FRAME_BITS = 193,
  parameter int BIT_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             resync,
  input logic             sync_mf_sel,
  input logic             sync_dbl_en,
  input logic             blk_wr_en,
  input logic             sync_out,
  input logic             fsync_out,
  input logic             msync_out,
  input logic             chblk_out,
  input logic             fbit,
  input logic [BIT_W-1:0] bit_idx
);

  logic [15:0] gap;
  logic        armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap   <= '0;
      armed <= 1'b0;
    end else if (resync) begin
      gap   <= '0;
      armed <= 1'b0;
    end else if (fsync_out) begin
      gap   <= 16'd1;
      armed <= 1'b1;
    end else begin
      gap   <= gap + 16'd1;
    end
  end

  AST_RESYNC_FRAME1: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (fsync_out && msync_out && !chblk_out)); // R1

  AST_FSYNC_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync_out && !resync) |=> !fsync_out); // R2

  AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync_out && armed) |-> (gap == 16'(FRAME_BITS))); // R2

  AST_MSYNC_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    msync_out |-> fsync_out); // R3

  AST_SYNC_MF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mf_sel |-> (sync_out == msync_out)); // R4

  AST_SYNC_FRAME_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mf_sel && !sync_dbl_en) |-> (sync_out == fsync_out)); // R5

  AST_SYNC_DBL_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mf_sel && sync_out && !fsync_out) |-> $past(fsync_out)); // R6

  AST_BLK_STABLE_IN_CH: assert property (@(posedge clk) disable iff (!rst_n)
    (!fbit && bit_idx != '0 && !$past(blk_wr_en)) |-> $stable(chblk_out)); // R7

  AST_BLK_LOW_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_out |-> !chblk_out); // R8

endmodule

bind t1_rx_timing t1_rx_timing_chk #(.FRAME_BITS(FRAME_BITS), .BIT_W(BIT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .resync(resync), .sync_mf_sel(sync_mf_sel),
  .sync_dbl_en(sync_dbl_en), .blk_wr_en(blk_wr_en), .sync_out(sync_out),
  .fsync_out(fsync_out), .msync_out(msync_out), .chblk_out(chblk_out),
  .fbit(fbit), .bit_idx(bit_idx)
);

// File: tb/test_t1_rx_timing.sv
`timescale 1ns/1ps
module test_t1_rx_timing;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic resync = 1'b0, esf_mode = 1'b0, sync_mf_sel = 1'b0, sync_dbl_en = 1'b0;
  logic blk_wr_en = 1'b0;
  logic [1:0] blk_wr_addr = '0;
  logic [7:0] blk_wr_data = '0;
  logic sync_out, fsync_out, msync_out, chblk_out;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  t1_rx_timing i_t1_rx_timing (
    .clk(clk), .rst_n(rst_n), .resync(resync), .esf_mode(esf_mode),
    .sync_mf_sel(sync_mf_sel), .sync_dbl_en(sync_dbl_en),
    .blk_wr_en(blk_wr_en), .blk_wr_addr(blk_wr_addr), .blk_wr_data(blk_wr_data),
    .sync_out(sync_out), .fsync_out(fsync_out), .msync_out(msync_out),
    .chblk_out(chblk_out)
  );

  // Behavioural reference: position 0 = framing bit, 1..192 = channel bits.
  int m_pos = 0, m_frame = 0;
  bit [23:0] m_en = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_frame = 0; m_en = '0;
    end else begin
      if (blk_wr_en && blk_wr_addr != 2'd3)
        for (int k = 0; k < 8; k++) m_en[blk_wr_addr*8 + k] = blk_wr_data[k];
      if (resync) begin
        m_pos = 0; m_frame = 0;
      end else if (m_pos == 192) begin
        m_pos = 0;
        m_frame = (m_frame + 1 >= (esf_mode ? 24 : 12)) ? 0 : m_frame + 1;
      end else begin
        m_pos = m_pos + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, sampled mid low phase.
  always @(negedge clk) begin
    #1.5;
    if (rst_n && !done) begin
      bit e_f, e_m, e_s, e_b, sig;
      e_f = (m_pos == 0);
      e_m = (m_pos == 0) && (m_frame == 0);
      sig = ((m_frame + 1) % 6) == 0;
      e_s = sync_mf_sel ? e_m : (e_f || (sync_dbl_en && sig && m_pos == 1));
      e_b = (m_pos != 0) && m_en[(m_pos - 1) / 8];
      chk(fsync_out == e_f, "R2", "fsync_out", fsync_out, e_f);
      chk(msync_out == e_m, "R3", "msync_out", msync_out, e_m);
      chk(sync_out == e_s, sync_mf_sel ? "R4" : (sync_dbl_en ? "R6" : "R5"),
          "sync_out", sync_out, e_s);
      chk(chblk_out == e_b, (m_pos == 0) ? "R8" : "R7", "chblk_out", chblk_out, e_b);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    blk_wr_en = 1'b1; blk_wr_addr = a; blk_wr_data = d;
    step();
    blk_wr_en = 1'b0;
  endtask

  task automatic wait_fsync();
    while (!fsync_out) step();
  endtask

  task automatic wait_msync();
    while (!msync_out) step();
  endtask

  // sel: 0 fsync, 1 msync, 2 sync, 3 chblk
  task automatic count_high(input int n, input int sel, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      case (sel)
        0: cnt += fsync_out;
        1: cnt += msync_out;
        2: cnt += sync_out;
        default: cnt += chblk_out;
      endcase
      step();
    end
  endtask

  initial begin
    int c;
    step(); step(); step();
    // R1: reset state
    chk(fsync_out === 1'b1, "R1", "fsync in reset", fsync_out, 1);
    chk(msync_out === 1'b1, "R1", "msync in reset", msync_out, 1);
    chk(chblk_out === 1'b0, "R1", "chblk in reset", chblk_out, 0);
    rst_n = 1'b1;
    step();
    // R9: enable bytes
    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'h81);

    // R2: frame spacing
    step(); wait_fsync();
    c = 0; do begin step(); c++; end while (!fsync_out);
    chk(c == 193, "R2", "frame spacing", c, 193);

    // R5: plain frame sync, 12 per SF multiframe
    wait_msync();
    count_high(12*193, 2, c);
    chk(c == 12, "R5", "sync pulses per SF multiframe", c, 12);

    // R6: widened on frames 6 and 12
    sync_dbl_en = 1'b1;
    step(); wait_msync();
    count_high(12*193, 2, c);
    chk(c == 14, "R6", "sync cycles per SF multiframe", c, 14);

    // R3 / R4: multiframe length in both formats
    sync_mf_sel = 1'b1;
    step(); wait_msync();
    c = 0; do begin step(); c++; end while (!msync_out);
    chk(c == 12*193, "R3", "SF multiframe length", c, 12*193);
    esf_mode = 1'b1;
    step(); wait_msync();
    c = 0; do begin step(); c++; end while (!msync_out);
    chk(c == 24*193, "R3", "ESF multiframe length", c, 24*193);
    count_high(24*193, 2, c);
    chk(c == 1, "R4", "multiframe sync count", c, 1);

    // R6 in ESF: frames 6,12,18,24
    sync_mf_sel = 1'b0;
    step(); wait_msync();
    count_high(24*193, 2, c);
    chk(c == 28, "R6", "sync cycles per ESF multiframe", c, 28);

    // R3: format change midstream past frame 12 wraps to frame 1
    for (int i = 0; i < 15*193; i++) step();
    esf_mode = 1'b0;
    for (int i = 0; i < 30*193; i++) step();

    // R1: resync mid-frame
    for (int i = 0; i < 57; i++) step();
    resync = 1'b1; step(); resync = 1'b0;
    chk(fsync_out == 1'b1 && msync_out == 1'b1, "R1", "frame 1 after resync",
        {fsync_out, msync_out}, 3);
    step();
    chk(chblk_out == 1'b1, "R1", "channel 1 bit 1 after resync", chblk_out, 1);

    // R7 / R8: all channels enabled
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
    wait_fsync();
    count_high(193, 3, c);
    chk(c == 192, "R7", "chblk cycles with all enabled", c, 192);

    // R9: clear, then address 3 must change nothing
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    wr(2'd3, 8'hFF);
    wait_fsync();
    count_high(193, 3, c);
    chk(c == 0, "R9", "chblk after address 3 write", c, 0);

    // R7: single channel 24
    wr(2'd2, 8'h80);
    wait_fsync();
    count_high(193, 3, c);
    chk(c == 8, "R7", "chblk cycles for channel 24", c, 8);

    for (int i = 0; i < 500; i++) step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog R1: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule